// File: doc/BRIEF.md
# Suspend Modulation Duty-Cycle Generator

This block throttles a processor core by driving an active-low suspend line in a repeating pattern. While the line is low the core idles; while it is high the core runs. Each low (ON) phase and each high (OFF) phase lasts a programmable number of fixed ticks. The tick is nominally 32 µs and is made from the system clock by a prescaler. The average throughput of the core is the full rate scaled by OFF / (OFF + ON).

Software programs the block through a small byte-wide register port that uses plain write-strobe and combinational-read pins. There is no streaming data path, so no pin needs a valid/ready handshake.

Two speedup timers, one for interrupt activity and one for video activity, can override the throttling:
- An activity pulse on an enabled input loads that input's timer with a hold time counted in milliseconds.
- While either timer is non-zero, the suspend line is held high.
- When both timers reach zero, modulation restarts with an ON phase.

Top module: `susp_mod_gen`

## Requirements
- R1: After reset `susp_n` is 1 and every register reads 0.
- R2: Register addresses are:
  - 0: OFF count (8 bits).
  - 1: ON count (8 bits).
  - 2: control. Bit 0 enables modulation, bit 1 enables interrupt speedup, bit 2 enables video speedup. Bits 7..3 read 0.
  - 3: interrupt hold (ms).
  - 4: video hold (ms).

  A write lands on the clock edge where `reg_wr` is 1. Writes to addresses 5 to 7 change nothing, and those addresses read 0.
- R3: With modulation enabled, `susp_n` alternates between two phases, ON first. It is 0 for ON×TICK_DIV clocks and then 1 for OFF×TICK_DIV clocks. Every phase is exact except the first one after a restart.
- R4: When modulation is disabled, `susp_n` is 1 from the next clock onward.
- R5: A phase whose count is zero is skipped. ON=0 with OFF>0 keeps `susp_n` at 1. OFF=0 with ON>0 keeps it at 0. ON=OFF=0 keeps it at 1.
- R6: A count written during a phase does not change that phase. It takes effect at the next phase boundary.
- R7: An `irq_activity` pulse while control bit 1 is set holds `susp_n` at 1 from the next clock. The hold lasts the interrupt hold value × MS_TICKS ticks (the first tick may be partial). Modulation then resumes with an ON phase.
- R8: A `video_activity` pulse while control bit 2 is set does the same, using the video hold value.
- R9: An activity pulse whose speedup enable bit is clear has no effect on `susp_n`.
- R10: A new activity pulse during a running hold reloads that timer to its full hold value. The timer count never rises except on such a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_activity | input | 1 | Interrupt activity event (level; every high cycle reloads) |
| video_activity | input | 1 | Video activity event (level; every high cycle reloads) |
| susp_n | output | 1 | Active-low suspend to the core |

## Verification
The assertions assume the following about the inputs:
- Reset is applied before the first checked edge.
- Activity inputs and register writes are synchronous to `clk`.
- TICK_DIV and MS_TICKS are at least 1.

The bench drives every input half a period away from the rising edge. It shrinks TICK_DIV and MS_TICKS so that phase lengths and hold windows stay at a few dozen clocks. It compares each measured phase length with count × TICK_DIV. Measurement starts only after the first, partial phase has passed. Hold windows are checked against their shortest and longest possible lengths, because the first millisecond tick of a hold may be partial.

// File: rtl/smod_pkg.sv
package smod_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_OFF_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ON_CNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQ_HOLD = 3'd3;
  localparam logic [ADDR_W-1:0] A_VID_HOLD = 3'd4;

  localparam int B_MOD_EN = 0;
  localparam int B_IRQ_EN = 1;
  localparam int B_VID_EN = 2;

  localparam int N_SPEEDUP = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_ON, PH_OFF} phase_t;
endpackage

// File: rtl/smod_prescaler.sv
module smod_prescaler #(
  parameter int TICK_DIV = 8000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (cnt_q == PW'(TICK_DIV - 1))   cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == PW'(TICK_DIV - 1));

      // R3: a tick is one clock wide when the divider is above one
      p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/smod_regs.sv
module smod_regs
  import smod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  off_cnt,
  output logic [REG_W-1:0]  on_cnt,
  output logic              mod_en,
  output logic              irq_en,
  output logic              vid_en,
  output logic [REG_W-1:0]  irq_hold,
  output logic [REG_W-1:0]  vid_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt  <= '0;
      on_cnt   <= '0;
      mod_en   <= 1'b0;
      irq_en   <= 1'b0;
      vid_en   <= 1'b0;
      irq_hold <= '0;
      vid_hold <= '0;
    end else if (wr) begin
      case (addr)
        A_OFF_CNT:  off_cnt  <= wdata;
        A_ON_CNT:   on_cnt   <= wdata;
        A_CTRL: begin
          mod_en <= wdata[B_MOD_EN];
          irq_en <= wdata[B_IRQ_EN];
          vid_en <= wdata[B_VID_EN];
        end
        A_IRQ_HOLD: irq_hold <= wdata;
        A_VID_HOLD: vid_hold <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_OFF_CNT:  rdata = off_cnt;
      A_ON_CNT:   rdata = on_cnt;
      A_CTRL: begin
        rdata[B_MOD_EN] = mod_en;
        rdata[B_IRQ_EN] = irq_en;
        rdata[B_VID_EN] = vid_en;
      end
      A_IRQ_HOLD: rdata = irq_hold;
      A_VID_HOLD: rdata = vid_hold;
      default:    rdata = '0;
    endcase
  end

  // R2: a strobe to an unmapped address leaves the counts as they were
  p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr > A_VID_HOLD) |=> ($stable(off_cnt) && $stable(on_cnt)));
endmodule

// File: rtl/smod_speedup_timer.sv
module smod_speedup_timer #(
  parameter int MS_TICKS = 31,
  parameter int HOLD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              event_in,
  input  logic              tick,
  input  logic [HOLD_W-1:0] reload,
  output logic              active
);
  localparam int SW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

  logic [HOLD_W-1:0] ms_q;
  logic [SW-1:0]     sub_q;
  logic              sub_wrap;

  assign sub_wrap = (sub_q == SW'(MS_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sub_q <= '0;
    end else if (!enable) begin
      ms_q  <= '0;
      sub_q <= '0;
    end else if (event_in) begin
      ms_q  <= reload;
      sub_q <= '0;
    end else if (tick && ms_q != '0) begin
      if (sub_wrap) begin
        sub_q <= '0;
        ms_q  <= ms_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign active = (ms_q != '0);

  // R10: without a reload the remaining hold never grows
  p_hold_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !event_in) |=> (ms_q <= $past(ms_q)));

  // R9: a disabled timer is empty one clock later, whatever its event input does
  p_disabled_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active);
endmodule

// File: rtl/smod_phase_seq.sv
module smod_phase_seq
  import smod_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] on_cnt,
  input  logic [CNT_W-1:0] off_cnt,
  output logic             susp_n
);
  phase_t           ph_q;
  logic [CNT_W-1:0] rem_q;
  logic             on_zero, off_zero, boundary;

  assign on_zero  = (on_cnt == '0);
  assign off_zero = (off_cnt == '0);
  assign boundary = tick && (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      rem_q <= '0;
    end else if (!run) begin
      ph_q  <= PH_IDLE;
      rem_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (!on_zero) begin
            ph_q <= PH_ON;  rem_q <= on_cnt;
          end else if (!off_zero) begin
            ph_q <= PH_OFF; rem_q <= off_cnt;
          end
        end
        PH_ON: begin
          if (boundary) begin
            if (!off_zero) begin
              ph_q <= PH_OFF; rem_q <= off_cnt;
            end else if (!on_zero) begin
              ph_q <= PH_ON;  rem_q <= on_cnt;
            end else begin
              ph_q <= PH_IDLE; rem_q <= '0;
            end
          end else if (tick) begin
            rem_q <= rem_q - 1'b1;
          end
        end
        PH_OFF: begin
          if (boundary) begin
            if (!on_zero) begin
              ph_q <= PH_ON;  rem_q <= on_cnt;
            end else if (!off_zero) begin
              ph_q <= PH_OFF; rem_q <= off_cnt;
            end else begin
              ph_q <= PH_IDLE; rem_q <= '0;
            end
          end else if (tick) begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          rem_q <= '0;
        end
      endcase
    end
  end

  assign susp_n = (ph_q != PH_ON);

  // R4: a stopped sequencer releases the suspend line on the next clock
  p_release_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> susp_n);

  // R3: an active phase always has ticks left to run
  p_phase_has_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (rem_q != '0));

  // R6: inside a phase, between boundaries, the remaining count only moves down by one tick
  p_no_midphase_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_q != PH_IDLE && !boundary) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/susp_mod_gen.sv
module susp_mod_gen
  import smod_pkg::*;
#(
  parameter int TICK_DIV = 8000,
  parameter int MS_TICKS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              irq_activity,
  input  logic              video_activity,
  output logic              susp_n
);
  logic             tick;
  logic [REG_W-1:0] off_cnt, on_cnt, irq_hold, vid_hold;
  logic             mod_en, irq_en, vid_en;
  logic             hold, run;

  logic [N_SPEEDUP-1:0] sp_en, sp_evt, sp_act;
  logic [REG_W-1:0]     sp_reload [N_SPEEDUP];

  smod_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  smod_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .off_cnt(off_cnt), .on_cnt(on_cnt), .mod_en(mod_en),
    .irq_en(irq_en), .vid_en(vid_en), .irq_hold(irq_hold), .vid_hold(vid_hold)
  );

  assign sp_en        = {vid_en, irq_en};
  assign sp_evt       = {video_activity, irq_activity};
  assign sp_reload[0] = irq_hold;
  assign sp_reload[1] = vid_hold;

  generate
    for (genvar i = 0; i < N_SPEEDUP; i++) begin : g_sp
      smod_speedup_timer #(.MS_TICKS(MS_TICKS), .HOLD_W(REG_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .enable(sp_en[i]), .event_in(sp_evt[i]),
        .tick(tick), .reload(sp_reload[i]), .active(sp_act[i])
      );
    end
  endgenerate

  assign hold = |sp_act;
  assign run  = mod_en && !hold;

  smod_phase_seq #(.CNT_W(REG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .on_cnt(on_cnt), .off_cnt(off_cnt), .susp_n(susp_n)
  );

  // R7: any running speedup hold keeps the core at full speed from the next clock
  p_speedup_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> susp_n);

  // R8: an enabled video pulse gives full speed one clock after its timer loads
  p_video_full_speed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && video_activity && vid_hold != '0) |=> ##1 susp_n);
endmodule

// File: tb/sim_susp_mod_gen.sv
module sim_susp_mod_gen;
  localparam int DIV = 4;
  localparam int MS  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_activity = 1'b0;
  logic       video_activity = 1'b0;
  logic       susp_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  susp_mod_gen #(.TICK_DIV(DIV), .MS_TICKS(MS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_activity(irq_activity),
    .video_activity(video_activity), .susp_n(susp_n)
  );

  // stimulus vectors {off, on}: alternating patterns for R3
  localparam logic [15:0] VEC [0:4] = '{
    {8'd3, 8'd2}, {8'd1, 8'd1}, {8'd5, 8'd3}, {8'd2, 8'd6}, {8'd7, 8'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic wait_for(input logic v, output int t);
    t = 0;
    while (susp_n !== v && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic measure(input logic v, output int n);
    n = 0;
    while (susp_n === v && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_irq();
    irq_activity = 1'b1; @(negedge clk); irq_activity = 1'b0;
  endtask

  task automatic pulse_vid();
    video_activity = 1'b1; @(negedge clk); video_activity = 1'b0;
  endtask

  // count cycles over a window where susp_n differs from v
  task automatic hold_level(input logic v, input int len, output int bad);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      if (susp_n !== v) bad++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [7:0] off, input logic [7:0] on, input logic [7:0] ctrl);
    wr(3'd2, 8'h00);
    wr(3'd0, off);
    wr(3'd1, on);
    wr(3'd2, ctrl);
    repeat (3) @(negedge clk);
  endtask

  task automatic const_case(input logic [7:0] off, input logic [7:0] on, input logic v);
    int bad;
    setup(off, on, 8'h01);
    hold_level(v, 60, bad);
    check(bad == 0, "R5 zero-count phase skipped", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int t, lo, hi, bad;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(susp_n === 1'b1, "R1 susp_n after reset", int'(susp_n), 1);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check(d == 8'h00, "R1 register reset value", d, 0);
    end

    // R2 register map
    wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd3, 8'h11); wr(3'd4, 8'h22);
    wr(3'd2, 8'hF8);
    rd(3'd2, d); check(d == 8'h00, "R2 ctrl upper bits", d, 0);
    wr(3'd7, 8'hFF); wr(3'd5, 8'hEE);
    rd(3'd0, d); check(d == 8'h5A, "R2 off count readback", d, 8'h5A);
    rd(3'd1, d); check(d == 8'hC3, "R2 on count readback", d, 8'hC3);
    rd(3'd3, d); check(d == 8'h11, "R2 irq hold readback", d, 8'h11);
    rd(3'd4, d); check(d == 8'h22, "R2 video hold readback", d, 8'h22);
    rd(3'd7, d); check(d == 8'h00, "R2 unmapped read", d, 0);
    check(susp_n === 1'b1, "R2 ctrl bit0 clear keeps susp_n high", int'(susp_n), 1);

    // R3 vector walk
    for (int v = 0; v < 5; v++) begin
      setup(VEC[v][15:8], VEC[v][7:0], 8'h01);
      wait_for(1'b1, t);
      wait_for(1'b0, t);
      measure(1'b0, lo);
      measure(1'b1, hi);
      check(lo == int'(VEC[v][7:0]) * DIV, "R3 ON phase length", lo, int'(VEC[v][7:0]) * DIV);
      check(hi == int'(VEC[v][15:8]) * DIV, "R3 OFF phase length", hi, int'(VEC[v][15:8]) * DIV);
    end

    // R4 disable mid ON phase
    setup(8'd2, 8'd6, 8'h01);
    wait_for(1'b1, t); wait_for(1'b0, t);
    wr(3'd2, 8'h00);
    @(negedge clk);
    hold_level(1'b1, 30, bad);
    check(bad == 0, "R4 disable releases susp_n", bad, 0);

    // R5 zero counts
    const_case(8'd0, 8'd4, 1'b0);
    const_case(8'd4, 8'd0, 1'b1);
    const_case(8'd0, 8'd0, 1'b1);

    // R6 count written mid-phase
    setup(8'd2, 8'd10, 8'h01);
    wait_for(1'b1, t); wait_for(1'b0, t);
    wr(3'd1, 8'd3);
    measure(1'b0, lo);
    check(lo + 1 == 10 * DIV, "R6 current ON phase unchanged", lo + 1, 10 * DIV);
    measure(1'b1, hi);
    measure(1'b0, lo);
    check(lo == 3 * DIV, "R6 new ON count at next boundary", lo, 3 * DIV);

    // R7 interrupt speedup hold
    wr(3'd3, 8'd2);
    setup(8'd1, 8'd255, 8'h03);
    wait_for(1'b0, t);
    pulse_irq();
    @(negedge clk);
    hold_level(1'b1, 18, bad);
    check(bad == 0, "R7 irq hold keeps susp_n high", bad, 0);
    wait_for(1'b0, t);
    check(t <= 20, "R7 modulation resumes after hold", t, 20);

    // R10 retrigger extends hold
    repeat (4) @(negedge clk);
    pulse_irq();
    repeat (14) @(negedge clk);
    pulse_irq();
    repeat (14) @(negedge clk);
    check(susp_n === 1'b1, "R10 retrigger reloads irq hold", int'(susp_n), 1);
    wait_for(1'b0, t);
    check(t <= 30, "R10 resume after retriggered hold", t, 30);

    // R9 event with speedup disabled
    wr(3'd2, 8'h01);
    repeat (3) @(negedge clk);
    wait_for(1'b0, t);
    pulse_irq();
    pulse_vid();
    hold_level(1'b0, 20, bad);
    check(bad == 0, "R9 disabled speedup ignored", bad, 0);

    // R8 video speedup hold
    wr(3'd4, 8'd5);
    wr(3'd2, 8'h05);
    wait_for(1'b0, t);
    pulse_vid();
    @(negedge clk);
    hold_level(1'b1, 50, bad);
    check(bad == 0, "R8 video hold keeps susp_n high", bad, 0);
    wait_for(1'b0, t);
    check(t <= 20, "R8 modulation resumes after video hold", t, 20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule